// File: doc/BRIEF.md
# SPI Slave Serial Front End with Transfer Pause

This block is the bit-level layer of an SPI memory slave. It runs entirely in the system clock domain. The chip-select, serial clock, serial data in and pause inputs pass through two-flop synchronizers, and SCK edges are found by comparing successive synchronized samples. The system clock must run at least eight times faster than SCK. Received bits are assembled most significant bit first into bytes for the command layer. Transmit bytes are taken from the command layer and shifted out on SO, together with an output-enable for the pad tri-state.

Only SPI modes 0 and 3 are served. In both modes the input is sampled on the rising SCK edge and SO moves on the falling SCK edge. A falling SCK edge that comes before any rising edge of the current byte, which is the first edge of a mode 3 session, does not shift. The host can freeze a transfer with the active-low pause input and resume it later at the same bit.

A three-state controller governs the session. The states are `FE_IDLE` (chip-select high), `FE_ACTIVE` (bits move) and `FE_PAUSED` (SCK ignored, SO released). The transitions are:
- start: `FE_IDLE` to `FE_ACTIVE` on a chip-select fall.
- pause: `FE_ACTIVE` to `FE_PAUSED` when the pause input is low while SCK is low.
- resume: `FE_PAUSED` to `FE_ACTIVE` when the pause input is high while SCK is low.
- end: `FE_ACTIVE` or `FE_PAUSED` to `FE_IDLE` on a chip-select rise.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, `so_oe`, `rx_valid`, `tx_req`, `session_start` and `session_end` are all low.
- R2: A chip-select fall in `FE_IDLE` gives a one-cycle `session_start` pulse, clears the bit counter and loads `tx_byte`, so that its bit 7 is on `so_pin` before the first rising SCK edge.
- R3: SI is sampled on rising SCK edges, first bit into bit 7. After every eighth rising edge of a session, `rx_byte` holds the assembled byte and `rx_valid` is high for exactly one cycle.
- R4: `so_pin` shifts only on a falling SCK edge that follows a rising edge in the same byte, so modes 0 and 3 deliver identical bit streams. Bit k of a byte (k = 1 to 8) is `tx` bit 8-k before rising edge k.
- R5: The falling edge after the eighth rising edge of a byte loads `tx_byte` (its bit 7 goes to `so_pin`). On that edge `tx_req` pulses for one cycle if `tx_en` is high, and it never pulses while `tx_en` is low.
- R6: `so_oe` is high only in `FE_ACTIVE` with `tx_en` high. It is low whenever chip-select is high.
- R7: The pause input low while SCK is low enters `FE_PAUSED`. There `so_oe` is low and SCK edges change neither the received byte nor `so_pin`.
- R8: Pause input high while SCK is low resumes at the same bit position. A pause input fall while SCK is high takes effect only at the next SCK low, and that falling SCK edge is still processed.
- R9: A chip-select rise in `FE_ACTIVE` or `FE_PAUSED` gives a one-cycle `session_end` pulse and drops any partial byte with no `rx_valid`. The next session starts at bit 0.
- R10: A chip-select rise that reaches the synchronizers together with an eighth rising SCK edge ends the session with no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip-select, active low, asynchronous |
| sck_pin | input | 1 | Serial clock from host, asynchronous |
| si_pin | input | 1 | Serial data in |
| hold_n_pin | input | 1 | Transfer pause, active low |
| tx_en | input | 1 | Command layer drives SO in this phase |
| tx_byte | input | 8 | Next byte to transmit |
| so_pin | output | 1 | Serial data out value |
| so_oe | output | 1 | Output-enable for the SO pad |
| rx_byte | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe, new `rx_byte` |
| tx_req | output | 1 | One-cycle strobe, `tx_byte` consumed |
| session_start | output | 1 | One-cycle strobe at session start |
| session_end | output | 1 | One-cycle strobe at session end |

## Verification
Two collisions are covered. The first is the eighth rising SCK edge arriving in the same system cycle as the chip-select rise. The bench changes both pins at the same instant, so they pass the synchronizers together. It then requires a single `session_end` and an empty receive scoreboard, because any `rx_valid` would pop a byte that was never expected. The second is a pause request that arrives while SCK is high. Here the falling SCK edge and the pause entry are seen in the same cycle. The bench requires that the edge is still shifted out and that the next bit read after resume is the correct one.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    typedef enum logic [1:0] {
        FE_IDLE   = 2'd0,
        FE_ACTIVE = 2'd1,
        FE_PAUSED = 2'd2
    } fe_state_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= d;
    end
    assign rise = d & ~prev;
    assign fall = ~d & prev;
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         rise,
    input  logic         fall,
    input  logic         si,
    input  logic         tx_en,
    input  logic [W-1:0] tx_byte,
    output logic         so_bit,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid,
    output logic         tx_req
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  rx_sh;
    logic [W-1:0]  tx_sh;
    logic          pend;   // a rising edge awaits its falling edge (R4)
    logic          full;   // eighth rising edge seen, reload at next fall (R5)

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_byte  <= '0;
            pend     <= 1'b0;
            full     <= 1'b0;
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (start || abort) begin
                cnt   <= '0;
                rx_sh <= '0;
                pend  <= 1'b0;
                full  <= 1'b0;
                if (start) tx_sh <= tx_byte;
            end else if (rise) begin
                rx_sh <= {rx_sh[W-2:0], si};
                pend  <= 1'b1;
                if (cnt == LAST) begin
                    rx_byte  <= {rx_sh[W-2:0], si};
                    rx_valid <= 1'b1;
                    cnt      <= '0;
                    full     <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (fall && pend) begin
                pend <= 1'b0;
                if (full) begin
                    tx_sh  <= tx_byte;
                    full   <= 1'b0;
                    tx_req <= tx_en;
                end else begin
                    tx_sh <= {tx_sh[W-2:0], 1'b0};
                end
            end
        end
    end

    assign so_bit = tx_sh[W-1];
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
    import spi_fe_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n_pin,
    input  logic         sck_pin,
    input  logic         si_pin,
    input  logic         hold_n_pin,
    input  logic         tx_en,
    input  logic [W-1:0] tx_byte,
    output logic         so_pin,
    output logic         so_oe,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid,
    output logic         tx_req,
    output logic         session_start,
    output logic         session_end
);
    // packed pin order {hold, si, sck, cs}
    localparam int   NPIN = 4;
    localparam logic [NPIN-1:0] PIN_RST = 4'b1001;

    logic [NPIN-1:0] pins_s;
    logic            cs_s, sck_s, si_s, hold_s;
    logic [1:0]      e_rise, e_fall;
    logic            cs_rise_e, cs_fall_e, sck_rise_e, sck_fall_e;

    fe_state_t state_q, state_d;

    spi_fe_sync #(.WIDTH(NPIN), .STAGES(STAGES), .RST_VAL(PIN_RST)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({hold_n_pin, si_pin, sck_pin, cs_n_pin}),
        .q(pins_s)
    );
    assign {hold_s, si_s, sck_s, cs_s} = pins_s;

    spi_fe_edge #(.WIDTH(2), .RST_VAL(2'b01)) i_edge (
        .clk(clk), .rst_n(rst_n),
        .d({sck_s, cs_s}),
        .rise(e_rise), .fall(e_fall)
    );
    assign {sck_rise_e, cs_rise_e} = e_rise;
    assign {sck_fall_e, cs_fall_e} = e_fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FE_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, pause, resume, end
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FE_IDLE:   if (cs_fall_e)              state_d = FE_ACTIVE;
            FE_ACTIVE: if (cs_rise_e)              state_d = FE_IDLE;
                       else if (!hold_s && !sck_s) state_d = FE_PAUSED;
            FE_PAUSED: if (cs_rise_e)              state_d = FE_IDLE;
                       else if (hold_s && !sck_s)  state_d = FE_ACTIVE;
            default:                               state_d = FE_IDLE;
        endcase
    end

    logic in_active, start_g, rise_g, fall_g;
    assign in_active = (state_q == FE_ACTIVE);
    assign start_g   = (state_q == FE_IDLE) && cs_fall_e;
    // chip-select rise outranks an SCK edge in the same cycle (R10)
    assign rise_g    = in_active && sck_rise_e && !cs_rise_e;
    assign fall_g    = in_active && sck_fall_e && !cs_rise_e;

    spi_fe_shift #(.W(W)) i_shift (
        .clk(clk), .rst_n(rst_n),
        .start(start_g), .abort(cs_rise_e),
        .rise(rise_g), .fall(fall_g),
        .si(si_s), .tx_en(tx_en), .tx_byte(tx_byte),
        .so_bit(so_pin), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .tx_req(tx_req)
    );

    // output process: session strobes (R2, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            session_start <= 1'b0;
            session_end   <= 1'b0;
        end else begin
            session_start <= start_g;
            session_end   <= cs_rise_e && (state_q != FE_IDLE);
        end
    end

    assign so_oe = in_active && tx_en;   // R6, R7
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker
    import spi_fe_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n_pin,
    input logic         sck_pin,
    input logic         hold_n_pin,
    input logic         tx_en,
    input logic         so_pin,
    input logic         so_oe,
    input logic [W-1:0] rx_byte,
    input logic         rx_valid,
    input logic         tx_req,
    input logic         session_start,
    input logic         session_end,
    input fe_state_t    state_q
);
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        session_start |=> !session_start);

    p_start_end_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(session_start && session_end));

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_txreq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tx_en) |-> !tx_req);

    p_cs_high_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n_pin, 1) && $past(cs_n_pin, 2) && $past(cs_n_pin, 3)) |-> !so_oe);

    p_pause_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!hold_n_pin, 1) && $past(!hold_n_pin, 2) && $past(!hold_n_pin, 3)
         && $past(!sck_pin, 3) && $past(!cs_n_pin, 3) && $past(!cs_n_pin, 4)) |-> !so_oe);

    p_paused_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FE_PAUSED && $past(state_q == FE_PAUSED)) |-> ($stable(so_pin) && $stable(rx_byte) && !rx_valid));

    p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        session_end |=> !session_end);
endmodule

bind spi_hold_frontend spi_fe_checker #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
    .hold_n_pin(hold_n_pin), .tx_en(tx_en), .so_pin(so_pin), .so_oe(so_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req),
    .session_start(session_start), .session_end(session_end), .state_q(state_q)
);

// File: tb/test_spi_hold_frontend.sv
module test_spi_hold_frontend;
    localparam int HALF = 8;   // system cycles per SCK half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, tx_en = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       so_pin, so_oe, rx_valid, tx_req, session_start, session_end;
    logic [7:0] rx_byte;

    int checks = 0, failures = 0;
    int n_start = 0, n_end = 0, n_txreq = 0;
    logic [7:0] exp_q[$];
    logic p_valid = 0, p_start = 0, p_end = 0, p_req = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    spi_hold_frontend i_spi_hold_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .si_pin(si),
        .hold_n_pin(hold_n), .tx_en(tx_en), .tx_byte(tx_byte),
        .so_pin(so_pin), .so_oe(so_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_req(tx_req), .session_start(session_start), .session_end(session_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard for received bytes, pulse counts and widths
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) chk(0, "R9/R10 unexpected rx_valid", rx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_byte == e, "R3 rx_byte", rx_byte, e);
                end
            end
            if (rx_valid && p_valid) chk(0, "R3 rx_valid width", 2, 1);
            if (session_start && p_start) chk(0, "R2 session_start width", 2, 1);
            if (session_end && p_end) chk(0, "R9 session_end width", 2, 1);
            if (tx_req && p_req) chk(0, "R5 tx_req width", 2, 1);
            if (session_start && !p_start) n_start++;
            if (session_end && !p_end) n_end++;
            if (tx_req && !p_req) n_txreq++;
            p_valid = rx_valid; p_start = session_start; p_end = session_end; p_req = tx_req;
        end
    end

    // one byte; kind 1 pauses with SCK low before bit hb, kind 2 with SCK high after bit hb
    task automatic xfer(input logic [7:0] mosi, input logic [7:0] miso, input logic [7:0] nxt,
                        input int hb, input int kind);
        if (mosi !== 8'hxx) exp_q.push_back(mosi);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = mosi[i];
            wclk(HALF);
            if (i == 7) tx_byte = nxt;
            if (kind == 1 && i == hb) begin
                hold_n = 1'b0;
                wclk(6);
                chk(so_oe == 1'b0, "R7 oe low in pause", so_oe, 0);
                for (int t = 0; t < 2; t++) begin
                    si = ~si; sck = 1'b1; wclk(HALF);
                    sck = 1'b0; wclk(HALF);
                end
                si = mosi[i];
                hold_n = 1'b1;
                wclk(6);
                chk(so_oe == tx_en, "R8 oe after resume", so_oe, tx_en);
            end
            if (tx_en) begin
                chk(so_oe == 1'b1, "R6 oe in session", so_oe, 1);
                chk(so_pin == miso[i], "R4 so bit", so_pin, miso[i]);
            end else begin
                chk(so_oe == 1'b0, "R6 oe without tx_en", so_oe, 0);
            end
            sck = 1'b1;
            wclk(HALF);
            if (kind == 2 && i == hb) begin
                hold_n = 1'b0;
                wclk(4);
                chk(so_oe == tx_en, "R8 pause ignored while SCK high", so_oe, tx_en);
                sck = 1'b0;
                wclk(HALF);
                chk(so_oe == 1'b0, "R7 pause at SCK low", so_oe, 0);
                hold_n = 1'b1;
                wclk(HALF);
                chk(so_oe == tx_en, "R8 resume", so_oe, tx_en);
            end
        end
    endtask

    task automatic begin_session(input logic [7:0] first, input logic idle_sck);
        sck = idle_sck;
        tx_byte = first;
        wclk(4);
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic end_session();
        cs_n = 1'b1;
        wclk(HALF);
        chk(so_oe == 1'b0, "R6 oe low after CS high", so_oe, 0);
    endtask

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(1);
        chk(so_oe == 0, "R1 so_oe", so_oe, 0);
        chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
        chk(tx_req == 0 && session_start == 0 && session_end == 0, "R1 strobes", tx_req, 0);
        wclk(4);

        // mode 0, two bytes
        begin_session(8'hA5, 1'b0);
        chk(n_start == 1, "R2 session_start", n_start, 1);
        chk(so_pin == 1'b1 && so_oe == 1'b1, "R2 first bit ready", so_pin, 1);
        xfer(8'h3C, 8'hA5, 8'h5A, -1, 0);
        xfer(8'hC3, 8'h5A, 8'h00, -1, 0);
        sck = 1'b0; wclk(HALF);
        chk(n_txreq == 2, "R5 tx_req mode 0", n_txreq, 2);
        end_session();
        chk(n_end == 1, "R9 session_end", n_end, 1);

        // mode 3, two bytes: leading falling edge must not shift
        begin_session(8'h81, 1'b1);
        xfer(8'h96, 8'h81, 8'h7E, -1, 0);
        xfer(8'h11, 8'h7E, 8'hFF, -1, 0);
        end_session();
        chk(n_txreq == 3, "R5 tx_req mode 3", n_txreq, 3);
        chk(n_start == 2 && n_end == 2, "R2 R9 session counts", n_end, 2);

        // pause with SCK low, then pause requested with SCK high
        begin_session(8'hB2, 1'b0);
        xfer(8'hE7, 8'hB2, 8'h69, 4, 1);
        xfer(8'h4D, 8'h69, 8'h00, 2, 2);
        sck = 1'b0; wclk(HALF);
        end_session();

        // partial byte dropped, next session restarts at bit 0
        begin_session(8'hF0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            si = i[0]; sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
        end
        end_session();
        chk(n_end == 4, "R9 end after partial", n_end, 4);
        begin_session(8'h2B, 1'b0);
        xfer(8'h2B, 8'h2B, 8'h00, -1, 0);
        sck = 1'b0; wclk(HALF);
        end_session();

        // CS rise together with eighth rising edge
        begin_session(8'h00, 1'b0);
        for (int i = 7; i > 0; i--) begin
            sck = 1'b0; si = 1'b1; wclk(HALF); sck = 1'b1; wclk(HALF);
        end
        sck = 1'b0; wclk(HALF);
        sck = 1'b1; cs_n = 1'b1;
        wclk(HALF);
        chk(n_end == 6, "R10 collision session_end", n_end, 6);
        chk(exp_q.size() == 0, "R10 no byte", exp_q.size(), 0);

        // transmit disabled
        tx_en = 1'b0;
        begin_session(8'hAA, 1'b0);
        xfer(8'h5C, 8'h00, 8'h00, -1, 0);
        sck = 1'b0; wclk(HALF);
        end_session();
        chk(n_txreq == 6, "R5 no tx_req without tx_en", n_txreq, 6);
        tx_en = 1'b1;

        wclk(8);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule